// File: doc/BRIEF.md
# Watchdog Timer with Reset-Source Flags

This block is a 16-bit up-counting watchdog for a microcontroller core. After every reset the counter is enabled and counts up from zero. It advances on a divided core clock, with a choice of two division ratios. Software must service the watchdog in time. A service strobe loads the counter's high byte from a programmable reload field and clears the low byte. If the counter wraps past its maximum while enabled, the block raises a one-cycle reset request and restarts itself, and a watchdog flag in its control word records the event.

Just after reset there is a short window in which a disable strobe may switch the watchdog off. The first service or end-of-initialization strobe closes that window. After that, disable strobes are ignored until the next reset or watchdog restart. The control word also records which reset source was reported: software, short hardware or long hardware. Each is reported by a single-cycle input pulse. Software can write only the reload byte and the prescaler select. The count itself can be read but has no write path.

Top module: `wdt_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, `count_o` is 0x0000, `ctrl_o` is 0x0000 and `wd_rst_req` is 0. The counter then runs enabled with no software action.
- R2: With `ctrl_o[0]` = 0 the count advances by one every 2 clocks. With `ctrl_o[0]` = 1 it advances by one every 128 clocks. After a reset, a service or a watchdog restart, the first increment comes one full division period later.
- R3: A service pulse loads `count_o` with `{ctrl_o[15:8], 8'h00}`, using the reload byte held before that edge.
- R4: When the count wraps from 0xFFFF while enabled, `wd_rst_req` is high for exactly one cycle. On that edge `count_o` becomes 0x0000 and `ctrl_o` becomes 0x0002: the watchdog flag in bit 1 is set, and the reload byte, the select bit and the source flags are cleared. The watchdog stays enabled.
- R5: A service pulse clears the watchdog flag, bit 1 of `ctrl_o`.
- R6: A disable pulse that arrives while the window is open stops the count, and the count then holds its value. Both reset and a watchdog restart open the window.
- R7: Once a service or end-of-initialization pulse has been seen, disable pulses have no effect until the next reset or watchdog restart.
- R8: Pulses on `sw_rst_seen`, `short_hw_rst_seen` and `long_hw_rst_seen` set `ctrl_o` bits 2, 3 and 4 respectively. These flags stay set through service pulses and register writes.
- R9: A register write changes only `ctrl_o[15:8]` (reload byte) and `ctrl_o[0]` (select). Bits 7:5 always read 0, and bits 4:1 are not writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| svc_pulse | input | 1 | Service strobe, one cycle |
| dis_pulse | input | 1 | Disable request strobe, one cycle |
| init_done_pulse | input | 1 | End-of-initialization strobe, one cycle |
| sw_rst_seen | input | 1 | Software reset source indication |
| short_hw_rst_seen | input | 1 | Short hardware reset source indication |
| long_hw_rst_seen | input | 1 | Long hardware reset source indication |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write data |
| count_o | output | 16 | Current count, read-only |
| ctrl_o | output | 16 | Control word: reload, flags, select |
| wd_rst_req | output | 1 | Watchdog reset request, one cycle |

## Verification
The assertions check four things on every cycle. The reset request never lasts more than one cycle. A stopped watchdog keeps its count and never overflows. The count never moves by more than one step, and once the window has closed nothing can switch the watchdog off. The cycle-exact scenarios are left to the bench: the prescale timing for both ratios, the reload loading for a sweep of reload values, the wrap from 0xFFFF, and the order in which the window is opened and closed. These need computed timelines that a single-cycle property cannot express.

// File: rtl/wdt_pkg.sv
// Package: field positions and widths shared by the watchdog modules.
// Assumes a 16-bit control word with the reload byte in the upper half.
package wdt_pkg;
    localparam int CNT_W      = 16;
    localparam int RELOAD_W   = 8;
    localparam int SEL_BIT    = 0;
    localparam int WDFLAG_BIT = 1;
    localparam int SRC_LO     = 2;
    localparam int SRC_N      = 3;
    localparam int RELOAD_LO  = 8;
endpackage

// File: rtl/wdt_prescaler.sv
// Module: free-running clock divider for the watchdog count.
// Produces a one-cycle tick every 2**LO_LOG2 clocks (sel=0) or every
// 2**HI_LOG2 clocks (sel=1). It restarts from zero on reset or restart, so
// the first tick comes a full period later. Assumes HI_LOG2 >= LO_LOG2 >= 1.
module wdt_prescaler #(
    parameter int LO_LOG2 = 1,
    parameter int HI_LOG2 = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sel,
    output logic tick
);
    logic [HI_LOG2-1:0] div_q;

    // Divider register: clears on reset or restart, otherwise counts freely.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    // Tick when the selected low bits of the divider are all ones.
    always_comb begin
        tick = sel ? (&div_q[HI_LOG2-1:0]) : (&div_q[LO_LOG2-1:0]);
    end
endmodule

// File: rtl/wdt_ctrl.sv
// Module: control word, enable state and disable window of the watchdog.
// Holds the reload byte, the select bit, the watchdog flag and the source
// flags. An overflow restart takes priority over every other update.
// Assumes all strobes are single-cycle pulses.
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ovf,
    input  logic                svc,
    input  logic                dis,
    input  logic                init_done,
    input  logic [SRC_N-1:0]    src_seen,
    input  logic                wr_en,
    input  logic [CNT_W-1:0]    wr_data,
    output logic                en,
    output logic                sel,
    output logic [RELOAD_W-1:0] reload,
    output logic [CNT_W-1:0]    ctrl_word
);
    logic             win_q;
    logic             wdflag_q;
    logic [SRC_N-1:0] src_q;

    // Enable and window: a reset or restart opens the window, and service or init-done closes it.
    always_ff @(posedge clk) begin
        if (!rst_n || ovf) begin
            en    <= 1'b1;
            win_q <= 1'b1;
        end else begin
            if (dis && win_q)     en    <= 1'b0;
            if (svc || init_done) win_q <= 1'b0;
        end
    end

    // Writable fields: reload byte and select bit, both cleared by a restart.
    always_ff @(posedge clk) begin
        if (!rst_n || ovf) begin
            reload <= '0;
            sel    <= 1'b0;
        end else if (wr_en) begin
            reload <= wr_data[RELOAD_LO +: RELOAD_W];
            sel    <= wr_data[SEL_BIT];
        end
    end

    // Watchdog flag: set by an overflow, cleared by a system reset or a service.
    always_ff @(posedge clk) begin
        if (!rst_n)   wdflag_q <= 1'b0;
        else if (ovf) wdflag_q <= 1'b1;
        else if (svc) wdflag_q <= 1'b0;
    end

    // Source flags: one sticky bit for each reset-source input.
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n || ovf)   src_q[i] <= 1'b0;
            else if (src_seen[i]) src_q[i] <= 1'b1;
        end
    end

    // Assemble the control word; the reserved bits stay zero.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[RELOAD_LO +: RELOAD_W] = reload;
        ctrl_word[SRC_LO +: SRC_N]       = src_q;
        ctrl_word[WDFLAG_BIT]            = wdflag_q;
        ctrl_word[SEL_BIT]               = sel;
    end

    // R7
    // Once the window is closed, the watchdog cannot be switched off.
    closed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !win_q) |=> en);

    // R5
    // A service without an overflow leaves the watchdog flag clear.
    svc_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && !ovf) |=> !ctrl_word[WDFLAG_BIT]);
endmodule

// File: rtl/wdt_counter.sv
// Module: 16-bit watchdog count with overflow detection and the one-cycle
// reset request. It detects the overflow combinationally and registers the
// request, so the request follows the wrapping edge. Assumes `tick` comes
// from the prescaler.
module wdt_counter
    import wdt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                tick,
    input  logic                svc,
    input  logic [RELOAD_W-1:0] reload,
    output logic                ovf,
    output logic [CNT_W-1:0]    count,
    output logic                rst_req
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int               LOW_W   = CNT_W - RELOAD_W;

    // Overflow: an enabled tick while the count is at its maximum.
    always_comb begin
        ovf = en && tick && (count == CNT_MAX);
    end

    // Count register: a restart wins, then a service reload, then an increment.
    always_ff @(posedge clk) begin
        if (!rst_n || ovf)   count <= '0;
        else if (svc)        count <= {reload, {LOW_W{1'b0}}};
        else if (en && tick) count <= count + 1'b1;
    end

    // Reset request: a one-cycle pulse after each overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= ovf;
    end

    // R4
    // The reset request never lasts longer than one cycle.
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4
    // After an overflow the count has restarted from zero.
    ovf_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (count == '0) && rst_req);

    // R6
    // A stopped watchdog holds its count unless it is serviced.
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !svc) |=> $stable(count));

    // R6
    // A stopped watchdog never requests a reset.
    stopped_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !ovf);

    // R2
    // Without a service or overflow the count moves by at most one step.
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc && !ovf) |=> (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/wdt_unit.sv
// Module: watchdog timer top. It connects the prescaler, the control word
// and the counter. A service or an overflow restarts the prescaler. Assumes
// that the system reset generator, the instruction decode and the bus
// decode are outside this block.
module wdt_unit
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_pulse,
    input  logic        dis_pulse,
    input  logic        init_done_pulse,
    input  logic        sw_rst_seen,
    input  logic        short_hw_rst_seen,
    input  logic        long_hw_rst_seen,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] count_o,
    output logic [15:0] ctrl_o,
    output logic        wd_rst_req
);
    logic                en;
    logic                sel;
    logic                tick;
    logic                ovf;
    logic [RELOAD_W-1:0] reload;
    logic                pre_restart;

    // Prescaler restart: a service or an overflow both begin a fresh period.
    always_comb begin
        pre_restart = svc_pulse || ovf;
    end

    wdt_prescaler #(.LO_LOG2(1), .HI_LOG2(7)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (pre_restart),
        .sel     (sel),
        .tick    (tick)
    );

    wdt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf       (ovf),
        .svc       (svc_pulse),
        .dis       (dis_pulse),
        .init_done (init_done_pulse),
        .src_seen  ({long_hw_rst_seen, short_hw_rst_seen, sw_rst_seen}),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .en        (en),
        .sel       (sel),
        .reload    (reload),
        .ctrl_word (ctrl_o)
    );

    wdt_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .tick    (tick),
        .svc     (svc_pulse),
        .reload  (reload),
        .ovf     (ovf),
        .count   (count_o),
        .rst_req (wd_rst_req)
    );

    // R9
    // The reserved bits of the control word always read zero.
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[7:5] == 3'b000);
endmodule

// File: tb/wdt_unit_tb_top.sv
// Testbench for wdt_unit: directed sweeps with expected counts computed
// from the prescale ratio and the number of edges since a restart.
module wdt_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        svc_pulse = 1'b0;
    logic        dis_pulse = 1'b0;
    logic        init_done_pulse = 1'b0;
    logic        sw_rst_seen = 1'b0;
    logic        short_hw_rst_seen = 1'b0;
    logic        long_hw_rst_seen = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_o;
    logic [15:0] ctrl_o;
    logic        wd_rst_req;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    wdt_unit dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .svc_pulse         (svc_pulse),
        .dis_pulse         (dis_pulse),
        .init_done_pulse   (init_done_pulse),
        .sw_rst_seen       (sw_rst_seen),
        .short_hw_rst_seen (short_hw_rst_seen),
        .long_hw_rst_seen  (long_hw_rst_seen),
        .wr_en             (wr_en),
        .wr_data           (wr_data),
        .count_o           (count_o),
        .ctrl_o            (ctrl_o),
        .wd_rst_req        (wd_rst_req)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(3);
        chk("R1 count", count_o, 16'h0000);
        chk("R1 ctrl", ctrl_o, 16'h0000);
        chk("R1 req", {15'd0, wd_rst_req}, 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic write_ctrl(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic svc();
        svc_pulse = 1'b1; step(1); svc_pulse = 1'b0;
    endtask

    task automatic dis();
        dis_pulse = 1'b1; step(1); dis_pulse = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] held;
        logic [7:0]  rel [5] = '{8'h00, 8'h01, 8'h5A, 8'hA5, 8'hFE};
        @(negedge clk);
        do_reset();

        // R1 R2: counting from zero at divide-by-2 right after reset.
        chk("R1 first cycle", count_o, 16'h0000);
        for (int m = 1; m <= 20; m++) begin
            step(1);
            chk("R2 div2 from reset", count_o, 16'(m / 2));
        end

        // R3 R2: service reload sweep at divide-by-2.
        for (int i = 0; i < 5; i++) begin
            write_ctrl({rel[i], 8'h00});
            svc();
            for (int m = 0; m <= 5; m++) begin
                chk("R3 reload", count_o, {rel[i], 8'h00} + 16'(m / 2));
                step(1);
            end
        end

        // R2: divide-by-128 with reload 0x12.
        write_ctrl(16'h1201);
        chk("R9 write sel", ctrl_o, 16'h1201);
        svc();
        step(127); chk("R2 div128 before", count_o, 16'h1200);
        step(1);   chk("R2 div128 first", count_o, 16'h1201);
        step(127); chk("R2 div128 hold", count_o, 16'h1201);
        step(1);   chk("R2 div128 second", count_o, 16'h1202);

        // R4: overflow from 0xFFFF with reload 0xFF at divide-by-2.
        write_ctrl(16'hFF00);
        svc();
        step(511);
        chk("R4 at max", count_o, 16'hFFFF);
        chk("R4 no req yet", {15'd0, wd_rst_req}, 16'h0000);
        step(1);
        chk("R4 wrap count", count_o, 16'h0000);
        chk("R4 wrap ctrl", ctrl_o, 16'h0002);
        chk("R4 req high", {15'd0, wd_rst_req}, 16'h0001);
        step(1);
        chk("R4 req one cycle", {15'd0, wd_rst_req}, 16'h0000);
        chk("R2 after restart", count_o, 16'h0000);
        step(1);
        chk("R2 first after restart", count_o, 16'h0001);

        // R6: the window is open again after the restart; disable stops the count.
        dis();
        held = count_o;
        step(300);
        chk("R6 frozen after restart", count_o, held);
        chk("R6 no req", {15'd0, wd_rst_req}, 16'h0000);
        svc();
        chk("R5 flag cleared", ctrl_o, 16'h0000);
        chk("R3 reload zero", count_o, 16'h0000);
        step(50);
        chk("R6 still stopped", count_o, 16'h0000);

        // R6: disable in the window opened by reset.
        do_reset();
        dis();
        step(20);
        chk("R6 frozen after reset", count_o, 16'h0000);

        // R7: init-done closes the window (1 + 1 + 10 edges gives count 6).
        do_reset();
        init_done_pulse = 1'b1; step(1); init_done_pulse = 1'b0;
        dis();
        step(10);
        chk("R7 ignored after init", count_o, 16'd6);

        // R7: service closes the window (service edge, then 10 edges gives count 5).
        do_reset();
        svc();
        dis();
        step(9);
        chk("R7 ignored after service", count_o, 16'd5);

        // R8 R9: source flags and write masking.
        do_reset();
        sw_rst_seen = 1'b1; step(1); sw_rst_seen = 1'b0;
        chk("R8 sw flag", ctrl_o, 16'h0004);
        short_hw_rst_seen = 1'b1; step(1); short_hw_rst_seen = 1'b0;
        chk("R8 short flag", ctrl_o, 16'h000C);
        long_hw_rst_seen = 1'b1; step(1); long_hw_rst_seen = 1'b0;
        chk("R8 long flag", ctrl_o, 16'h001C);
        write_ctrl(16'hFFFF);
        chk("R9 masked write", ctrl_o, 16'hFF1D);
        write_ctrl(16'h0000);
        chk("R9 flags not writable", ctrl_o, 16'h001C);
        svc();
        chk("R8 flags kept on service", ctrl_o, 16'h001C);
        do_reset();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule